// File: doc/BRIEF.md
# Modem Line Status and Loopback Unit

This unit holds the modem-control and modem-status state of a 16550-style serial port. The control register drives four handshake outputs: the request-to-send and terminal-ready outputs, and two general-purpose outputs. It also holds a loopback switch. The status register shows the current level of the four incoming handshake lines (carrier detect, ring, data-set-ready, clear-to-send). Its lower nibble holds sticky change flags for those lines.

The incoming lines are resynchronised into the core clock domain before any comparison is made. Every clock, the synchronised level is compared with the stored level, and a flag is raised for each line whose level has changed. The ring line is the exception: its flag is raised only when ring falls from 1 to 0. A read of the status register clears the change flags and leaves the levels alone. With loopback set, the status levels come from the unit's own control outputs, and the external lines are ignored. A single flag output reports that at least one change flag is set, so an interrupt controller elsewhere can use it.

The register port is a simple one-cycle access. Read data is combinational from the address, and a read strobe on the status address performs the clear.

Top module: `modem_line_unit`

## Requirements
- R1: After reset the control register reads 0x08 (only the second general output set), the status register reads 0xB0, out2_o is 1, rts_o, dtr_o and out1_o are 0, and delta_pending is 0.
- R2: A write to the control address stores wr_data[4:0] and reads back with bits 7:5 as zero. The outputs follow these bits: bit 0 drives dtr_o, bit 1 drives rts_o, bit 2 drives out1_o and bit 3 drives out2_o. Bit 4 is the loopback switch.
- R3: The status upper nibble is bit 7 carrier detect, bit 6 ring, bit 5 data-set-ready and bit 4 clear-to-send. A level change on an external input appears there SYNC_STAGES+1 rising edges after the input changes, and not sooner.
- R4: A change of the carrier-detect, data-set-ready or clear-to-send level sets status bit 3, bit 1 or bit 0 respectively. The bit stays set until a status read.
- R5: Status bit 2 is set when the ring level falls from 1 to 0, and is never set by a rising ring level.
- R6: A read strobe on the status address clears bits 3:0 at the next edge and keeps bits 7:4. A level change that lands on that same edge is still recorded.
- R7: With loopback set, the status levels come from the control register: general output 2 becomes carrier detect, general output 1 becomes ring, request-to-send becomes clear-to-send, and terminal-ready becomes data-set-ready. The levels follow two edges after the write, and the external inputs have no effect.
- R8: While loopback is set, rts_o and dtr_o are held at 0.
- R9: delta_pending is 1 exactly when any of status bits 3:0 is set.
- R10: A write to the status address changes nothing, and a read of any address other than the two register addresses returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect only on the status address) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from addr |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Terminal-ready output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| delta_pending | output | 1 | Any status change flag set |

## Verification
The bench builds the unit with its defaults: SYNC_STAGES of 2, a 3-bit address, the control register at 4 and the status register at 6. With two synchroniser stages, the bench can pin the exact edge on which an external change becomes visible. The register addresses leave other codes free, so the bench can test the unmapped read path. In loopback, only one register stage separates a control write from the status levels. This lets the bench place a level change on the same edge as a clearing read and confirm that the change survives.

// File: rtl/modem_pkg.sv
// Shared constants for the modem line unit.
// Line nibble order: [3] carrier detect, [2] ring, [1] data-set-ready, [0] clear-to-send.
package modem_pkg;
    localparam int REG_W    = 8;
    localparam int LINE_W   = 4;
    localparam int CTRL_W   = 5;

    localparam int LN_DCD   = 3;
    localparam int LN_RI    = 2;
    localparam int LN_DSR   = 1;
    localparam int LN_CTS   = 0;

    localparam int CB_DTR   = 0;
    localparam int CB_RTS   = 1;
    localparam int CB_OUT1  = 2;
    localparam int CB_OUT2  = 3;
    localparam int CB_LOOP  = 4;

    localparam logic [LINE_W-1:0] LINE_RST = 4'b1011;
    localparam logic [CTRL_W-1:0] CTRL_RST = 5'b01000;
    // Lines whose flag follows any change (ring is edge-selective)
    localparam logic [LINE_W-1:0] ANY_EDGE_MASK = 4'b1011;
endpackage

// File: rtl/modem_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes each bit is sampled on its own; no cross-bit coherence is promised.
// The reset value is a parameter so the output can match the register reset state.
module modem_sync #(
    parameter int                STAGES  = 2,
    parameter int                WIDTH   = 4,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES < 2) begin : g_single
            logic [WIDTH-1:0] stg_q;
            // single capture flop when only one stage is requested
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= RST_VAL;
                else        stg_q <= d;
            end
            assign q = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg_q;
            // shift the sampled bus through the stage chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= {STAGES{RST_VAL}};
                else        stg_q <= {stg_q[STAGES-2:0], d};
            end
            assign q = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/modem_ctrl_reg.sv
// Control register: five stored bits driving the handshake outputs.
// Assumes the caller decodes the address; wr_en here is already qualified.
// In loopback the request-to-send and terminal-ready outputs are forced low.
module modem_ctrl_reg
    import modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_bits,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              out1_o,
    output logic              out2_o
);
    // hold the control bits written by software
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= CTRL_RST;
        else if (wr_en) ctrl_q <= wr_bits;
    end

    // drive outputs; loopback isolates the line handshakes
    always_comb begin
        rts_o  = ctrl_q[CB_RTS] & ~ctrl_q[CB_LOOP];
        dtr_o  = ctrl_q[CB_DTR] & ~ctrl_q[CB_LOOP];
        out1_o = ctrl_q[CB_OUT1];
        out2_o = ctrl_q[CB_OUT2];
    end

    // R2: a write lands in the register on the next edge
    a_r2_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl_q == $past(wr_bits));

    // R8: loopback keeps the line handshakes inactive
    a_r8_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_LOOP] |-> (!rts_o && !dtr_o));
endmodule

// File: rtl/modem_status_reg.sv
// Status register: stored line levels plus sticky change flags.
// Assumes line_in is already in the clock domain. A clear and a new change on
// the same edge resolve in favour of the change.
module modem_status_reg
    import modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_in,
    input  logic              clr,
    output logic [LINE_W-1:0] lvl_q,
    output logic [LINE_W-1:0] dlt_q
);
    logic [LINE_W-1:0] chg;
    logic [LINE_W-1:0] set_vec;

    // classify changes: any edge for three lines, falling edge for ring
    always_comb begin
        chg             = line_in ^ lvl_q;
        set_vec         = chg & ANY_EDGE_MASK;
        set_vec[LN_RI]  = lvl_q[LN_RI] & ~line_in[LN_RI];
    end

    // track levels and accumulate flags, clearing on a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LINE_RST;
            dlt_q <= '0;
        end else begin
            lvl_q <= line_in;
            dlt_q <= (dlt_q & {LINE_W{~clr}}) | set_vec;
        end
    end

    // R4: a stored level change on the edge-any lines leaves its flag set
    a_r4_change_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (((lvl_q ^ $past(lvl_q)) & ANY_EDGE_MASK) != '0) |->
        ((dlt_q & (lvl_q ^ $past(lvl_q)) & ANY_EDGE_MASK) ==
         ((lvl_q ^ $past(lvl_q)) & ANY_EDGE_MASK)));

    // R5: a rising ring never raises the ring flag
    a_r5_ring_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl_q[LN_RI]) && !$past(dlt_q[LN_RI])) |-> !dlt_q[LN_RI]);

    // R6: a read with no concurrent change leaves all flags clear
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && $stable(lvl_q)) |-> (dlt_q == '0));
endmodule

// File: rtl/modem_line_unit.sv
// Top of the modem line unit: register decode, loopback selection, read mux.
// Assumes a single-cycle register port; rd_data is valid in the cycle of addr.
module modem_line_unit
    import modem_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter int                 ADDR_W      = 3,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR   = 3'd4,
    parameter logic [ADDR_W-1:0]  STAT_ADDR   = 3'd6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              cts_i,
    input  logic              dsr_i,
    input  logic              ri_i,
    input  logic              dcd_i,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              out1_o,
    output logic              out2_o,
    output logic              delta_pending
);
    localparam int PAD_W = REG_W - CTRL_W;

    logic [LINE_W-1:0] ext_raw;
    logic [LINE_W-1:0] ext_sync;
    logic [LINE_W-1:0] loop_line;
    logic [LINE_W-1:0] eff_line;
    logic [LINE_W-1:0] lvl_q;
    logic [LINE_W-1:0] dlt_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              ctrl_wr;
    logic              stat_clr;
    logic              unused_hi;

    assign ext_raw   = {dcd_i, ri_i, dsr_i, cts_i};
    assign unused_hi = ^wr_data[REG_W-1:CTRL_W];

    modem_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (LINE_W),
        .RST_VAL (LINE_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_raw),
        .q     (ext_sync)
    );

    // decode register strobes; status writes are dropped
    always_comb begin
        ctrl_wr  = wr_en && (addr == CTRL_ADDR);
        stat_clr = rd_en && (addr == STAT_ADDR);
    end

    modem_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_bits (wr_data[CTRL_W-1:0]),
        .ctrl_q  (ctrl_q),
        .rts_o   (rts_o),
        .dtr_o   (dtr_o),
        .out1_o  (out1_o),
        .out2_o  (out2_o)
    );

    // pick line source: external pins or the control cross-map
    always_comb begin
        loop_line[LN_DCD] = ctrl_q[CB_OUT2];
        loop_line[LN_RI]  = ctrl_q[CB_OUT1];
        loop_line[LN_DSR] = ctrl_q[CB_DTR];
        loop_line[LN_CTS] = ctrl_q[CB_RTS];
        eff_line = ctrl_q[CB_LOOP] ? loop_line : ext_sync;
    end

    modem_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (eff_line),
        .clr     (stat_clr),
        .lvl_q   (lvl_q),
        .dlt_q   (dlt_q)
    );

    // return register contents for the addressed location
    always_comb begin
        if (addr == CTRL_ADDR)      rd_data = {{PAD_W{1'b0}}, ctrl_q};
        else if (addr == STAT_ADDR) rd_data = {lvl_q, dlt_q};
        else                        rd_data = '0;
    end

    // flag any pending change for an external interrupt controller
    assign delta_pending = |dlt_q;

    // R7: in steady loopback the stored levels follow the control cross-map
    a_r7_loop_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_LOOP] && $past(ctrl_q[CB_LOOP]) && $stable(ctrl_q)) |->
        (lvl_q == {ctrl_q[CB_OUT2], ctrl_q[CB_OUT1], ctrl_q[CB_DTR], ctrl_q[CB_RTS]}));

    // R10: a status-address write never alters the control register
    a_r10_stat_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == STAT_ADDR) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_modem_line_unit.sv
module tb_modem_line_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
    logic       rts_o, dtr_o, out1_o, out2_o, delta_pending;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [2:0] CA = 3'd4;
    localparam logic [2:0] SA = 3'd6;

    modem_line_unit dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
        .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o),
        .delta_pending(delta_pending)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    // model: status value after a single level step from o to n, flags clean before
    function automatic logic [7:0] exp_stat(input logic [3:0] o, input logic [3:0] n);
        logic [3:0] d;
        d    = (o ^ n) & 4'b1011;
        d[2] = o[2] & ~n[2];
        return {n, d};
    endfunction

    // model: loopback cross-map from control bits to line nibble
    function automatic logic [3:0] loop_map(input logic [4:0] c);
        return {c[3], c[2], c[0], c[1]};
    endfunction

    task automatic set_ext(input logic [3:0] v);
        {dcd_i, ri_i, dsr_i, cts_i} = v;
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] v);
        addr = a; wr_data = v; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=finished");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        logic [3:0] cur, nxt;
        logic [4:0] cc, cn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wcyc(1);

        // R1 reset state
        do_rd(CA, v); check("R1 ctrl", v, 8'h08);
        do_rd(SA, v); check("R1 stat", v, 8'hB0);
        check("R1 outs", {4'd0, out2_o, out1_o, rts_o, dtr_o}, 8'h08);
        check("R1 pending", {7'd0, delta_pending}, 8'h00);

        // R2 control write, bit positions and masking
        do_wr(CA, 8'hE7); do_rd(CA, v); check("R2 mask", v, 8'h07);
        check("R2 outs", {4'd0, out2_o, out1_o, rts_o, dtr_o}, 8'h07);
        do_wr(CA, 8'h0A); do_rd(CA, v); check("R2 readback", v, 8'h0A);
        check("R2 outs2", {4'd0, out2_o, out1_o, rts_o, dtr_o}, 8'h0A);

        // R3 exact latency of an external change (clear-to-send falls)
        set_ext(4'b1010); addr = SA;
        wcyc(2); #1 check("R3 not yet", {4'd0, rd_data[7:4]}, 8'h0B);
        wcyc(1); #1 check("R3 visible", {4'd0, rd_data[7:4]}, 8'h0A);
        check("R4 cts flag", rd_data, 8'hA1);
        check("R9 pending set", {7'd0, delta_pending}, 8'h01);
        do_rd(SA, v);
        do_rd(SA, v); check("R6 cleared", v, 8'hA0);
        check("R9 pending clear", {7'd0, delta_pending}, 8'h00);

        // R5 ring rise then fall
        set_ext(4'b1110); wcyc(4); do_rd(SA, v); check("R5 ring rise", v, 8'hE0);
        set_ext(4'b1010); wcyc(4); do_rd(SA, v); check("R5 ring fall", v, 8'hA4);
        cur = 4'b1010;

        // R4 R5 R9 random external steps
        for (int i = 0; i < 40; i++) begin
            nxt = 4'($urandom());
            set_ext(nxt); wcyc(4);
            check("R9 pending rnd", {7'd0, delta_pending}, {7'd0, |exp_stat(cur, nxt)[3:0]});
            do_rd(SA, v); check("R4 rnd step", v, exp_stat(cur, nxt));
            cur = nxt;
        end

        // R7 R8 loopback cross-map with external noise
        cc = 5'h10;
        do_wr(CA, {3'd0, cc}); wcyc(2); do_rd(SA, v);
        for (int i = 0; i < 24; i++) begin
            cn = {1'b1, 4'($urandom())};
            set_ext(4'($urandom()));
            do_wr(CA, {3'd0, cn}); wcyc(3);
            check("R8 rts dtr low", {6'd0, rts_o, dtr_o}, 8'h00);
            check("R2 out loop", {6'd0, out2_o, out1_o}, {6'd0, cn[3], cn[2]});
            do_rd(SA, v); check("R7 loop step", v, exp_stat(loop_map(cc), loop_map(cn)));
            cc = cn;
        end

        // R6 change on the same edge as the clearing read
        do_wr(CA, 8'h10); wcyc(3); do_rd(SA, v);
        do_wr(CA, 8'h12);
        do_rd(SA, v); check("R6 read before change", v, 8'h00);
        do_rd(SA, v); check("R6 change kept", v, 8'h11);

        // R10 leave loopback, then status write and unmapped read
        set_ext(4'b0101); cur = 4'b0101;
        do_wr(CA, 8'h03); wcyc(4); do_rd(SA, v);
        check("R2 outs after loop", {4'd0, out2_o, out1_o, rts_o, dtr_o}, 8'h03);
        do_wr(SA, 8'hFF);
        do_rd(SA, v); check("R10 stat write ignored", v, {cur, 4'h0});
        do_rd(CA, v); check("R10 ctrl unchanged", v, 8'h03);
        do_rd(3'd0, v); check("R10 unmapped", v, 8'h00);
        do_rd(3'd7, v); check("R10 unmapped hi", v, 8'h00);

        finish_up();
    end
endmodule